// File: doc/BRIEF.md
# Command Slot Descriptor Sequencer

This block is the host-side front end of a single-port serial-storage host adapter. Software programs two base addresses through a small 32-bit register window: the command list and the received-FIS area. Software then writes the command-issue register. The block is a state machine that reads the command table base from the command list. It then reads the command FIS, the packet bytes and the first PRD entry through a 32-bit memory master with a request/acknowledge handshake, and decodes them into a single transfer request.

The transfer request carries the direction, the LBA, the sector count, the byte count, the 64-bit buffer address and the PRD length. It is presented to a downstream data mover as a one-cycle pulse. After every accepted command, the block writes a success status byte into the received-FIS area. Commands that need a packet device are dropped silently when the block is built without packet support.

States and transitions:
- S_IDLE moves to S_TABLE on an accepted issue write.
- S_TABLE moves to S_CMD when the table-base read is acknowledged.
- S_CMD moves to S_PRD after its sixth acknowledged read.
- S_PRD moves to S_DECODE after its third acknowledged read.
- S_DECODE moves to S_IDLE when the command is dropped, to S_ISSUE when it yields a transfer, and to S_STATUS otherwise.
- S_ISSUE always moves to S_STATUS.
- S_STATUS moves to S_IDLE when the status write is acknowledged.

Top module: `cmd_slot_seq`

## Requirements
- R1: After reset, busy, mem_req and xfer_valid are all low.
- R2: Register reads return the following, and every other offset reads 0:
  - 0x000 reads 1.
  - 0x004 reads the control register, which resets to 0 and is written at 0x004.
  - 0x00C reads 1.
  - 0x110 reads 1.
  - 0x128 reads 3.
- R3: A write to 0x138 while idle starts a command and raises busy on the next cycle. Busy stays high until the command ends. A write to 0x138 while busy is ignored, so exactly one transfer and one status write result.
- R4: The memory reads are issued in this order:
  - first, list base (written at 0x100) + 0x08, whose data becomes the table base;
  - then table base + 0x00, 0x04, 0x0C, 0x40, 0x44, 0x48, 0x80, 0x84 and 0x8C.
  
  Each request holds its address until mem_ack.
- R5: The opcode is bits 23:16 of the word at table + 0x00. Opcode 0xC8 gives a transfer with the following fields:
  - xfer_write = 0;
  - LBA = bits 23:0 of the word at table + 0x04;
  - count = bits 15:0 of the word at table + 0x0C;
  - bytes = count × 512.
- R6: Opcode 0xCA gives the same fields as R5, with xfer_write = 1.
- R7: With packet support, opcode 0xA0 whose packet byte 0 (bits 7:0 at table + 0x40) is 0x28 gives a read transfer with these fields, where packet byte n lies at table + 0x40 + n in little-endian dwords:
  - LBA = big-endian packet bytes 2..5;
  - count = big-endian packet bytes 7..8;
  - bytes = count × 2048.
- R8: The transfer address is {word at table + 0x84, word at table + 0x80}. The PRD length is bits 11:0 of the word at table + 0x8C.
- R9: xfer_valid is a single-cycle pulse, and all transfer fields are valid during it.
- R10: Every accepted command ends with one memory write to the received-FIS base (written at 0x108) + 0x40, with byte enable 4'b0100 and data 32'h0040_0000.
- R11: An accepted opcode other than the transfer cases gives no xfer_valid pulse but still gives the R10 status write. Examples are 0xEC, 0xA1, and 0xA0 with a packet byte 0 other than 0x28.
- R12: Without packet support, opcodes 0xA0 and 0xA1 give no transfer and no status write, and busy returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address (dword aligned) |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| xfer_valid | output | 1 | Transfer request pulse |
| xfer_write | output | 1 | Transfer direction: 1 host to device |
| xfer_lba | output | 32 | Starting LBA |
| xfer_count | output | 16 | Sector count |
| xfer_bytes | output | 32 | Byte count |
| xfer_addr | output | 64 | Buffer address from the first PRD |
| xfer_prd_len | output | 12 | First PRD length field |

## Verification
A wrong state or a wrong fetch index shows first on mem_addr, within the next acknowledged read, so the bench records the whole read sequence and compares it address by address. A mis-decoded opcode shows on the next xfer_valid pulse or the missing status write, within two cycles of the last PRD read. A stuck busy shows as a command that never ends, or as a second issue that is wrongly accepted. Each of these is caught by a count of pulses and status writes per command.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_TABLE, S_CMD, S_PRD, S_DECODE, S_ISSUE, S_STATUS
    } seq_state_t;

    typedef enum logic [1:0] {K_DROP, K_NONE, K_XFER} cmd_kind_t;

    localparam int NWORDS   = 9;
    localparam int CMD_LAST = 5;
    localparam int IDX_W    = 4;

    localparam logic [7:0] OP_DMA_RD  = 8'hC8;
    localparam logic [7:0] OP_DMA_WR  = 8'hCA;
    localparam logic [7:0] OP_PACKET  = 8'hA0;
    localparam logic [7:0] OP_PKT_ID  = 8'hA1;
    localparam logic [7:0] PKT_READ10 = 8'h28;

    localparam logic [7:0]  TBL_PTR_OFS = 8'h08;
    localparam logic [7:0]  STATUS_OFS  = 8'h40;
    localparam logic [3:0]  STATUS_BE   = 4'b0100;
    localparam logic [31:0] STATUS_WORD = 32'h0040_0000;

    typedef struct packed {
        logic        write;
        logic [31:0] lba;
        logic [15:0] count;
        logic [31:0] bytes;
        logic [63:0] addr;
        logic [11:0] prd_len;
    } xfer_t;

    // byte offset within the command table of each fetched word
    function automatic logic [7:0] word_offset(input logic [IDX_W-1:0] idx);
        unique case (idx)
            4'd0:    return 8'h00;
            4'd1:    return 8'h04;
            4'd2:    return 8'h0C;
            4'd3:    return 8'h40;
            4'd4:    return 8'h44;
            4'd5:    return 8'h48;
            4'd6:    return 8'h80;
            4'd7:    return 8'h84;
            default: return 8'h8C;
        endcase
    endfunction

endpackage

// File: rtl/cslot_regs.sv
module cslot_regs
    import cslot_pkg::*;
#(
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    output logic [31:0]       reg_rdata,
    output logic [31:0]       list_base,
    output logic [31:0]       fis_base,
    output logic              start
);
    localparam logic [REG_AW-1:0] A_CAPS  = REG_AW'(12'h000);
    localparam logic [REG_AW-1:0] A_CTL   = REG_AW'(12'h004);
    localparam logic [REG_AW-1:0] A_PIMPL = REG_AW'(12'h00C);
    localparam logic [REG_AW-1:0] A_LIST  = REG_AW'(12'h100);
    localparam logic [REG_AW-1:0] A_FIS   = REG_AW'(12'h108);
    localparam logic [REG_AW-1:0] A_ISTAT = REG_AW'(12'h110);
    localparam logic [REG_AW-1:0] A_PSTAT = REG_AW'(12'h128);
    localparam logic [REG_AW-1:0] A_ISSUE = REG_AW'(12'h138);

    logic [31:0] ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            list_base <= '0;
            fis_base  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTL)  ctl_q     <= reg_wdata;
            if (reg_addr == A_LIST) list_base <= reg_wdata;
            if (reg_addr == A_FIS)  fis_base  <= reg_wdata;
        end
    end

    assign start = reg_wr && (reg_addr == A_ISSUE) && !busy;

    always_comb begin
        unique case (reg_addr)
            A_CAPS:  reg_rdata = 32'd1;
            A_CTL:   reg_rdata = ctl_q;
            A_PIMPL: reg_rdata = 32'd1;
            A_ISTAT: reg_rdata = 32'd1;
            A_PSTAT: reg_rdata = 32'd3;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cslot_decode.sv
module cslot_decode
    import cslot_pkg::*;
#(
    parameter bit PACKET_DEV = 1'b1
) (
    input  logic [NWORDS-1:0][31:0] words,
    output cmd_kind_t               kind,
    output xfer_t                   xfer
);
    logic [7:0] opcode;
    assign opcode = words[0][23:16];

    always_comb begin
        kind         = K_NONE;
        xfer         = '0;
        xfer.addr    = {words[7], words[6]};
        xfer.prd_len = words[8][11:0];
        if ((opcode == OP_PACKET || opcode == OP_PKT_ID) && !PACKET_DEV) begin
            kind = K_DROP;
        end else if (opcode == OP_DMA_RD || opcode == OP_DMA_WR) begin
            kind       = K_XFER;
            xfer.write = (opcode == OP_DMA_WR);
            xfer.lba   = {8'h00, words[1][23:0]};
            xfer.count = words[2][15:0];
            xfer.bytes = {7'd0, words[2][15:0], 9'd0};
        end else if (opcode == OP_PACKET && words[3][7:0] == PKT_READ10) begin
            kind       = K_XFER;
            xfer.lba   = {words[3][23:16], words[3][31:24], words[4][7:0], words[4][15:8]};
            xfer.count = {words[4][31:24], words[5][7:0]};
            xfer.bytes = {5'd0, words[4][31:24], words[5][7:0], 11'd0};
        end
    end

endmodule

// File: rtl/cslot_seq.sv
module cslot_seq
    import cslot_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [31:0]             list_base,
    input  logic [31:0]             fis_base,
    input  cmd_kind_t               kind,
    input  logic                    mem_ack,
    input  logic [31:0]             mem_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [3:0]              mem_be,
    output logic [31:0]             mem_wdata,
    output logic [NWORDS-1:0][31:0] words,
    output logic                    xfer_fire,
    output logic                    busy
);
    localparam logic [IDX_W-1:0] CMD_END = IDX_W'(CMD_LAST);
    localparam logic [IDX_W-1:0] PRD_END = IDX_W'(NWORDS - 1);

    seq_state_t       state, nxt;
    logic [IDX_W-1:0] idx;
    logic [31:0]      tbase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            tbase <= '0;
            words <= '0;
        end else begin
            state <= nxt;
            if (start) idx <= '0;
            if (state == S_TABLE && mem_ack) tbase <= mem_rdata;
            if ((state == S_CMD || state == S_PRD) && mem_ack) begin
                words[idx] <= mem_rdata;
                idx        <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_TABLE;
            S_TABLE:  if (mem_ack) nxt = S_CMD;
            S_CMD:    if (mem_ack && idx == CMD_END) nxt = S_PRD;
            S_PRD:    if (mem_ack && idx == PRD_END) nxt = S_DECODE;
            S_DECODE: begin
                unique case (kind)
                    K_DROP:  nxt = S_IDLE;
                    K_XFER:  nxt = S_ISSUE;
                    default: nxt = S_STATUS;
                endcase
            end
            S_ISSUE:  nxt = S_STATUS;
            S_STATUS: if (mem_ack) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = 4'hF;
        mem_wdata = '0;
        xfer_fire = 1'b0;
        busy      = (state != S_IDLE);
        unique case (state)
            S_TABLE: begin
                mem_req  = 1'b1;
                mem_addr = ADDR_W'(list_base + 32'(TBL_PTR_OFS));
            end
            S_CMD, S_PRD: begin
                mem_req  = 1'b1;
                mem_addr = ADDR_W'(tbase + 32'(word_offset(idx)));
            end
            S_ISSUE: xfer_fire = 1'b1;
            S_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ADDR_W'(fis_base + 32'(STATUS_OFS));
                mem_be    = STATUS_BE;
                mem_wdata = STATUS_WORD;
            end
            default: ;
        endcase
    end

    // R4: an unacknowledged request keeps its address
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R9: transfer pulse lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_fire |=> !xfer_fire);
    // R10: a transfer is followed by the status write
    a_r10_status_next: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_fire |=> (mem_req && mem_we && mem_be == STATUS_BE));
    // R3: an accepted issue makes the block busy
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R12: a dropped command frees the block at once
    a_r12_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && kind == K_DROP) |=> !busy);

endmodule

// File: rtl/cmd_slot_seq.sv
module cmd_slot_seq
    import cslot_pkg::*;
#(
    parameter int REG_AW     = 12,
    parameter int ADDR_W     = 32,
    parameter bit PACKET_DEV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              xfer_valid,
    output logic              xfer_write,
    output logic [31:0]       xfer_lba,
    output logic [15:0]       xfer_count,
    output logic [31:0]       xfer_bytes,
    output logic [63:0]       xfer_addr,
    output logic [11:0]       xfer_prd_len
);
    logic [31:0]             list_base, fis_base;
    logic                    start;
    logic [NWORDS-1:0][31:0] words;
    cmd_kind_t               kind;
    xfer_t                   xfer;

    cslot_regs #(.REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .reg_rdata(reg_rdata),
        .list_base(list_base), .fis_base(fis_base), .start(start)
    );

    cslot_decode #(.PACKET_DEV(PACKET_DEV)) u_dec (
        .words(words), .kind(kind), .xfer(xfer)
    );

    cslot_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
        .fis_base(fis_base), .kind(kind), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .words(words), .xfer_fire(xfer_valid), .busy(busy)
    );

    assign xfer_write   = xfer.write;
    assign xfer_lba     = xfer.lba;
    assign xfer_count   = xfer.count;
    assign xfer_bytes   = xfer.bytes;
    assign xfer_addr    = xfer.addr;
    assign xfer_prd_len = xfer.prd_len;

endmodule

// File: tb/cmd_slot_seq_tb.sv
`timescale 1ns/1ps
module cmd_slot_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] mem [0:255];
    logic        ack = 1'b0;
    logic [31:0] rdata = '0;

    logic [31:0] d_rdata, a_rdata;
    logic        d_busy, d_req, d_we, d_xv, d_xw;
    logic        a_busy, a_req, a_we, a_xv, a_xw;
    logic [31:0] d_maddr, d_wd, a_maddr, a_wd, d_lba, a_lba, d_bytes, a_bytes;
    logic [3:0]  d_be, a_be;
    logic [15:0] d_cnt, a_cnt;
    logic [63:0] d_xa, a_xa;
    logic [11:0] d_pl, a_pl;

    cmd_slot_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr && !sel), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(d_rdata), .busy(d_busy),
        .mem_req(d_req), .mem_we(d_we), .mem_addr(d_maddr), .mem_be(d_be),
        .mem_wdata(d_wd), .mem_rdata(rdata), .mem_ack(ack && !sel),
        .xfer_valid(d_xv), .xfer_write(d_xw), .xfer_lba(d_lba),
        .xfer_count(d_cnt), .xfer_bytes(d_bytes), .xfer_addr(d_xa),
        .xfer_prd_len(d_pl)
    );

    cmd_slot_seq #(.PACKET_DEV(1'b0)) u_ata (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr && sel), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(a_rdata), .busy(a_busy),
        .mem_req(a_req), .mem_we(a_we), .mem_addr(a_maddr), .mem_be(a_be),
        .mem_wdata(a_wd), .mem_rdata(rdata), .mem_ack(ack && sel),
        .xfer_valid(a_xv), .xfer_write(a_xw), .xfer_lba(a_lba),
        .xfer_count(a_cnt), .xfer_bytes(a_bytes), .xfer_addr(a_xa),
        .xfer_prd_len(a_pl)
    );

    logic        m_req, m_we, busy_s;
    logic [31:0] m_addr;
    assign m_req  = sel ? a_req : d_req;
    assign m_we   = sel ? a_we : d_we;
    assign m_addr = sel ? a_maddr : d_maddr;
    assign busy_s = sel ? a_busy : d_busy;

    // memory responder and monitors
    int          n_wr = 0, n_pulse = 0, n_long = 0, tr_n = 0;
    logic [31:0] tr [0:15];
    logic [31:0] w_addr = '0, w_data = '0;
    logic [3:0]  w_be = '0;
    logic        c_w = 1'b0;
    logic [31:0] c_lba = '0, c_bytes = '0;
    logic [15:0] c_cnt = '0;
    logic [63:0] c_xa = '0;
    logic [11:0] c_pl = '0;
    logic        prev_xv = 1'b0;

    always @(posedge clk) begin
        ack   <= m_req && !ack;
        rdata <= mem[m_addr[9:2]];
        if (m_req && !ack && m_we) begin
            n_wr   <= n_wr + 1;
            w_addr <= m_addr;
            w_data <= sel ? a_wd : d_wd;
            w_be   <= sel ? a_be : d_be;
        end
        if (m_req && ack && !m_we && tr_n < 16) begin
            tr[tr_n] <= m_addr;
            tr_n     <= tr_n + 1;
        end
        prev_xv <= d_xv || a_xv;
        if ((d_xv || a_xv) && prev_xv) n_long <= n_long + 1;
        if (d_xv || a_xv) begin
            n_pulse <= n_pulse + 1;
            c_w     <= sel ? a_xw : d_xw;
            c_lba   <= sel ? a_lba : d_lba;
            c_cnt   <= sel ? a_cnt : d_cnt;
            c_bytes <= sel ? a_bytes : d_bytes;
            c_xa    <= sel ? a_xa : d_xa;
            c_pl    <= sel ? a_pl : d_pl;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = d_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy_s) break;
        end
    endtask

    // table at 0x100, list at 0x000, received area at 0x300
    task automatic setup(input logic [7:0] op, input logic [7:0] pkop);
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h02] = 32'h0000_0100;
        mem[8'h40] = {8'h00, op, 8'h00, 8'h27};
        mem[8'h41] = 32'hAB12_3456;
        mem[8'h43] = 32'hFFFF_0003;
        mem[8'h50] = {8'h12, 8'h01, 8'h00, pkop};
        mem[8'h51] = 32'h0000_5634;
        mem[8'h52] = 32'h0000_0005;
        mem[8'h60] = 32'h8000_0000;
        mem[8'h61] = 32'h0000_0001;
        mem[8'h63] = 32'hFFFF_F200;
    endtask

    task automatic issue(input logic which);
        sel = which;
        reg_wr(12'h100, 32'h0);
        reg_wr(12'h108, 32'h300);
        reg_wr(12'h138, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        #1;
        chk("R1 busy", d_busy, 0);
        chk("R1 req", d_req, 0);
        chk("R1 xfer", d_xv, 0);
        reg_rd(12'h000, v); chk("R2 caps", v, 1);
        reg_rd(12'h004, v); chk("R2 ctl reset", v, 0);
        reg_rd(12'h00C, v); chk("R2 ports", v, 1);
        reg_rd(12'h110, v); chk("R2 istat", v, 1);
        reg_rd(12'h128, v); chk("R2 pstat", v, 3);
        reg_rd(12'h200, v); chk("R2 other", v, 0);
        reg_wr(12'h004, 32'hCAFE_0001);
        reg_rd(12'h004, v); chk("R2 ctl write", v, 32'hCAFE_0001);
    endtask

    task automatic t_ata_read();
        int p0, w0;
        logic [31:0] exp_tr [0:9];
        setup(8'hC8, 8'h28);
        p0 = n_pulse; w0 = n_wr; tr_n = 0;
        issue(1'b0);
        chk("R3 busy after issue", d_busy, 1);
        wait_idle();
        exp_tr = '{32'h008, 32'h100, 32'h104, 32'h10C, 32'h140, 32'h144,
                   32'h148, 32'h180, 32'h184, 32'h18C};
        chk("R4 read count", tr_n, 10);
        for (int i = 0; i < 10; i++) chk("R4 read addr", tr[i], exp_tr[i]);
        chk("R9 one pulse", n_pulse - p0, 1);
        chk("R9 pulse width", n_long, 0);
        chk("R5 dir", c_w, 0);
        chk("R5 lba", c_lba, 32'h0012_3456);
        chk("R5 count", c_cnt, 3);
        chk("R5 bytes", c_bytes, 1536);
        chk("R8 addr", c_xa, 64'h1_8000_0000);
        chk("R8 len", c_pl, 12'h200);
        chk("R10 one write", n_wr - w0, 1);
        chk("R10 addr", w_addr, 32'h340);
        chk("R10 be", w_be, 4'b0100);
        chk("R10 data", w_data, 32'h0040_0000);
        chk("R3 idle at end", d_busy, 0);
    endtask

    task automatic t_ata_write();
        int p0;
        setup(8'hCA, 8'h00);
        p0 = n_pulse;
        issue(1'b0);
        wait_idle();
        chk("R6 one pulse", n_pulse - p0, 1);
        chk("R6 dir", c_w, 1);
        chk("R6 bytes", c_bytes, 1536);
    endtask

    task automatic t_packet_read();
        int p0;
        setup(8'hA0, 8'h28);
        p0 = n_pulse;
        issue(1'b0);
        wait_idle();
        chk("R7 one pulse", n_pulse - p0, 1);
        chk("R7 dir", c_w, 0);
        chk("R7 lba", c_lba, 32'h0112_3456);
        chk("R7 count", c_cnt, 5);
        chk("R7 bytes", c_bytes, 10240);
    endtask

    task automatic t_no_xfer(input logic [7:0] op, input logic [7:0] pk, input string tag);
        int p0, w0;
        setup(op, pk);
        p0 = n_pulse; w0 = n_wr;
        issue(1'b0);
        wait_idle();
        chk({"R11 no pulse ", tag}, n_pulse - p0, 0);
        chk({"R11 status ", tag}, n_wr - w0, 1);
        chk({"R11 data ", tag}, w_data, 32'h0040_0000);
    endtask

    task automatic t_busy_ignore();
        int p0, w0;
        setup(8'hC8, 8'h00);
        p0 = n_pulse; w0 = n_wr;
        issue(1'b0);
        reg_wr(12'h138, 32'h1);
        reg_wr(12'h138, 32'h1);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R3 ignored pulses", n_pulse - p0, 1);
        chk("R3 ignored writes", n_wr - w0, 1);
        chk("R3 idle", d_busy, 0);
    endtask

    task automatic t_drop(input logic [7:0] op);
        int p0, w0;
        setup(op, 8'h28);
        p0 = n_pulse; w0 = n_wr;
        issue(1'b1);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R12 no pulse", n_pulse - p0, 0);
        chk("R12 no status", n_wr - w0, 0);
        chk("R12 idle", a_busy, 0);
        sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ata_read();
        t_ata_write();
        t_packet_read();
        t_no_xfer(8'hEC, 8'h00, "EC");
        t_no_xfer(8'hA1, 8'h00, "A1");
        t_no_xfer(8'hA0, 8'h25, "pkt25");
        t_busy_ignore();
        t_drop(8'hA0);
        t_drop(8'hA1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule